// File: doc/BRIEF.md
# Configuration Byte Checksum Guard

This block protects a window of configuration bytes held in a small external byte-wide RAM. On a verify request it walks the window one byte per cycle, adds the bytes into a 16-bit total, and compares that total with a 16-bit value kept in two neighbouring bytes of the same RAM. If the two agree, the block reports completion and nothing is written. If they differ, it raises a sticky error flag and writes a fixed default value over every protected byte. It then stores the total of those defaults as the new checksum, so a later verify passes.

Firmware issues a verify request at start-up, before it uses any setting. After it has changed and saved settings it issues an update request. The block then sums the window again and writes the fresh total into the two checksum bytes. The RAM, its clock and any host-bus decoding sit outside the block. A two-flop synchronizer inside the block releases the asynchronous reset in step with the clock.

Top module: `cfg_sum_guard`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done` and `err` are low and the block drives neither a RAM read nor a RAM write until a request arrives.
- R2: A verify issues exactly 32 reads, one per cycle on consecutive cycles, at addresses 10h, 11h, … 2Fh in ascending order. Read data is taken one cycle after its address.
- R3: The computed total is the 16-bit sum of the zero-extended bytes at 10h..2Dh. The stored total is the byte at 2Fh (upper 8 bits) joined to the byte at 2Eh (lower 8 bits). When the two are equal, the verify ends with `err` low and no RAM write.
- R4: When the totals differ, `err` goes high and every byte a in 10h..2Dh is rewritten with ({a[3:0],a[7:4]} XOR 5Ah). Then 2Eh and 2Fh receive the lower and upper bytes of the 16-bit sum of those defaults, so a following verify passes.
- R5: An update reads 10h..2Dh, writes the lower byte of their 16-bit sum to 2Eh and the upper byte to 2Fh, and leaves `err` unchanged.
- R6: `busy` is high from the cycle after an accepted request until the operation finishes. `done` then pulses high for exactly one cycle, during which `busy` is already low.
- R7: A verify or update request that arrives while `busy` is high has no effect: no extra operation runs, no extra `done` pulse appears, and the RAM contents and `err` match those of the operation already in progress.
- R8: `err` stays high once set, through later updates, until the next accepted verify request clears it.
- R9: When both requests are high in the same idle cycle, the verify is performed and the update is dropped.
- R10: The block never writes a RAM address outside 10h..2Fh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| verify_req | input | 1 | Start a check of the protected window (sampled when idle) |
| update_req | input | 1 | Recompute and store the checksum (sampled when idle) |
| ram_rd_en | output | 1 | RAM read strobe; data returns on `ram_rdata` one cycle later |
| ram_wr_en | output | 1 | RAM write strobe |
| ram_addr | output | 8 | RAM byte address for the read or write |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, one cycle after the read strobe |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse at the end of an operation |
| err | output | 1 | Sticky checksum-mismatch flag |

## Verification
Verify runs on random window contents with a correct checksum, and on contents whose checksum has been damaged at random. These two cases separate the pass path from the default-restore path. Directed patterns cover an all-FFh window (the largest total, which exercises the carry into the upper byte), an all-zero window, and a checksum that is wrong only in its upper byte. That last case shows whether the compare uses all 16 bits. Requests that collide with a running operation or with each other, together with update after an error, show whether arbitration is correct and whether the error flag stays set until the next verify.

// File: rtl/cfgsum_pkg.sv
package cfgsum_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_VRD   = 3'd1,
    ST_URD   = 3'd2,
    ST_DRAIN = 3'd3,
    ST_CMP   = 3'd4,
    ST_DFLT  = 3'd5,
    ST_CSLO  = 3'd6,
    ST_CSHI  = 3'd7
  } guard_state_t;

endpackage

// File: rtl/cfgsum_rst_sync.sv
module cfgsum_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/cfgsum_walker.sv
// Address counter: loads a start address, steps by one, flags its last address.
module cfgsum_walker #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  input  logic [ADDR_W-1:0] last_val,
  output logic [ADDR_W-1:0] addr,
  output logic              at_last
);

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_d;
  logic              addr_en;

  always_comb begin
    addr_en = load | step;
    addr_d  = addr_q;
    if (load) begin
      addr_d = load_val;
    end else if (step) begin
      addr_d = addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  assign addr    = addr_q;
  assign at_last = (addr_q == last_val);

endmodule

// File: rtl/cfgsum_accum.sv
// Zero-extending byte accumulator.
module cfgsum_accum #(
  parameter int DATA_W = 8,
  parameter int SUM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              add_en,
  input  logic [DATA_W-1:0] din,
  output logic [SUM_W-1:0]  sum
);

  logic [SUM_W-1:0] sum_q;
  logic [SUM_W-1:0] sum_d;
  logic             sum_en;

  always_comb begin
    sum_en = clr | add_en;
    sum_d  = sum_q;
    if (clr) begin
      sum_d = '0;
    end else if (add_en) begin
      sum_d = sum_q + SUM_W'(din);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
    end else if (sum_en) begin
      sum_q <= sum_d;
    end
  end

  assign sum = sum_q;

endmodule

// File: rtl/cfgsum_dflt_rom.sv
// Default byte for an address: address halves swapped, then XOR with a key.
module cfgsum_dflt_rom #(
  parameter int          ADDR_W = 8,
  parameter int          DATA_W = 8,
  parameter logic [31:0] KEY    = 32'h5A
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);

  localparam int HALF = ADDR_W / 2;

  logic [ADDR_W-1:0] rot;

  generate
    if ((ADDR_W % 2) == 0) begin : g_even
      assign rot = {addr[HALF-1:0], addr[ADDR_W-1:HALF]};
    end else begin : g_odd
      assign rot = addr;
    end
  endgenerate

  assign data = DATA_W'(rot) ^ KEY[DATA_W-1:0];

endmodule

// File: rtl/cfg_sum_guard.sv
module cfg_sum_guard #(
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 8,
  parameter int          CFG_LO   = 'h10,
  parameter int          CFG_HI   = 'h2D,
  parameter int          CS_LO    = 'h2E,
  parameter int          CS_HI    = 'h2F,
  parameter logic [31:0] DFLT_KEY = 32'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              verify_req,
  input  logic              update_req,
  output logic              ram_rd_en,
  output logic              ram_wr_en,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              busy,
  output logic              done,
  output logic              err
);

  import cfgsum_pkg::*;

  localparam int                SUM_W     = 2 * DATA_W;
  localparam logic [ADDR_W-1:0] A_CFG_LO  = ADDR_W'(CFG_LO);
  localparam logic [ADDR_W-1:0] A_CFG_HI  = ADDR_W'(CFG_HI);
  localparam logic [ADDR_W-1:0] A_CS_LO   = ADDR_W'(CS_LO);
  localparam logic [ADDR_W-1:0] A_CS_HI   = ADDR_W'(CS_HI);

  logic rst_n_s;

  cfgsum_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  guard_state_t state_q, state_d;
  logic         vfy_q, vfy_d;
  logic         err_q, err_d;
  logic         done_q, done_d;
  logic         rd_vld_q;
  logic [ADDR_W-1:0] rd_addr_q;
  logic [DATA_W-1:0] st_lo_q, st_hi_q;
  logic         st_lo_en, st_hi_en;

  logic              walk_load, walk_step, walk_last;
  logic [ADDR_W-1:0] walk_addr, walk_end;
  logic              acc_clr, acc_add;
  logic [DATA_W-1:0] acc_din;
  logic [SUM_W-1:0]  acc_sum;
  logic [DATA_W-1:0] dflt_byte;
  logic              rd_in_cfg;

  cfgsum_walker #(.ADDR_W(ADDR_W)) u_walker (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load     (walk_load),
    .load_val (A_CFG_LO),
    .step     (walk_step),
    .last_val (walk_end),
    .addr     (walk_addr),
    .at_last  (walk_last)
  );

  cfgsum_accum #(.DATA_W(DATA_W), .SUM_W(SUM_W)) u_accum (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .clr    (acc_clr),
    .add_en (acc_add),
    .din    (acc_din),
    .sum    (acc_sum)
  );

  cfgsum_dflt_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY(DFLT_KEY)) u_dflt (
    .addr (walk_addr),
    .data (dflt_byte)
  );

  // Walk end: a verify also covers the two checksum bytes.
  assign walk_end  = (state_q == ST_VRD) ? A_CS_HI : A_CFG_HI;
  assign rd_in_cfg = rd_vld_q && (rd_addr_q >= A_CFG_LO) && (rd_addr_q <= A_CFG_HI);

  // Next-state logic
  always_comb begin
    state_d   = state_q;
    vfy_d     = vfy_q;
    err_d     = err_q;
    done_d    = 1'b0;
    walk_load = 1'b0;
    walk_step = 1'b0;
    acc_clr   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (verify_req) begin
          state_d   = ST_VRD;
          vfy_d     = 1'b1;
          err_d     = 1'b0;
          walk_load = 1'b1;
          acc_clr   = 1'b1;
        end else if (update_req) begin
          state_d   = ST_URD;
          vfy_d     = 1'b0;
          walk_load = 1'b1;
          acc_clr   = 1'b1;
        end
      end
      ST_VRD, ST_URD: begin
        walk_step = 1'b1;
        if (walk_last) begin
          state_d = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        state_d = vfy_q ? ST_CMP : ST_CSLO;
      end
      ST_CMP: begin
        if (acc_sum == {st_hi_q, st_lo_q}) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          state_d   = ST_DFLT;
          err_d     = 1'b1;
          walk_load = 1'b1;
          acc_clr   = 1'b1;
        end
      end
      ST_DFLT: begin
        walk_step = 1'b1;
        if (walk_last) begin
          state_d = ST_CSLO;
        end
      end
      ST_CSLO: begin
        state_d = ST_CSHI;
      end
      ST_CSHI: begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  // Accumulator feed: read data while scanning, default bytes while restoring.
  always_comb begin
    if (state_q == ST_DFLT) begin
      acc_add = 1'b1;
      acc_din = dflt_byte;
    end else begin
      acc_add = rd_in_cfg;
      acc_din = ram_rdata;
    end
  end

  assign st_lo_en = rd_vld_q && (rd_addr_q == A_CS_LO);
  assign st_hi_en = rd_vld_q && (rd_addr_q == A_CS_HI);

  // Registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q   <= ST_IDLE;
      vfy_q     <= 1'b0;
      err_q     <= 1'b0;
      done_q    <= 1'b0;
      rd_vld_q  <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      state_q   <= state_d;
      vfy_q     <= vfy_d;
      err_q     <= err_d;
      done_q    <= done_d;
      rd_vld_q  <= ram_rd_en;
      rd_addr_q <= ram_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_lo_q <= '0;
    end else if (st_lo_en) begin
      st_lo_q <= ram_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_hi_q <= '0;
    end else if (st_hi_en) begin
      st_hi_q <= ram_rdata;
    end
  end

  // RAM port
  always_comb begin
    ram_rd_en = (state_q == ST_VRD) || (state_q == ST_URD);
    ram_wr_en = (state_q == ST_DFLT) || (state_q == ST_CSLO) || (state_q == ST_CSHI);
    unique case (state_q)
      ST_CSLO: begin
        ram_addr  = A_CS_LO;
        ram_wdata = acc_sum[DATA_W-1:0];
      end
      ST_CSHI: begin
        ram_addr  = A_CS_HI;
        ram_wdata = acc_sum[SUM_W-1:DATA_W];
      end
      default: begin
        ram_addr  = walk_addr;
        ram_wdata = dflt_byte;
      end
    endcase
  end

  assign busy = (state_q != ST_IDLE);
  assign done = done_q;
  assign err  = err_q;

endmodule

// File: rtl/cfg_sum_guard_chk.sv
module cfg_sum_guard_chk #(
  parameter int ADDR_W = 8,
  parameter int CFG_LO = 'h10,
  parameter int CS_HI  = 'h2F
) (
  input logic              clk,
  input logic              rst_n,
  input logic              verify_req,
  input logic              update_req,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              ram_rd_en,
  input logic              ram_wr_en,
  input logic [ADDR_W-1:0] ram_addr
);

  // R10
  wr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_en |-> (ram_addr >= ADDR_W'(CFG_LO)) && (ram_addr <= ADDR_W'(CS_HI)));

  // R2
  rd_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_rd_en && $past(ram_rd_en)) |-> (ram_addr == $past(ram_addr) + 1'b1));

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(verify_req || update_req));

  // R8
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err) |-> $past(verify_req && !busy));

  // R4
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> busy);

  // R1
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_rd_en && ram_wr_en));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ram_rd_en && !ram_wr_en);

endmodule

bind cfg_sum_guard cfg_sum_guard_chk #(
  .ADDR_W (ADDR_W),
  .CFG_LO (CFG_LO),
  .CS_HI  (CS_HI)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .verify_req (verify_req),
  .update_req (update_req),
  .busy       (busy),
  .done       (done),
  .err        (err),
  .ram_rd_en  (ram_rd_en),
  .ram_wr_en  (ram_wr_en),
  .ram_addr   (ram_addr)
);

// File: tb/cfg_sum_guard_tb_top.sv
module cfg_sum_guard_tb_top;

  logic       clk;
  logic       rst_n;
  logic       verify_req;
  logic       update_req;
  logic       ram_rd_en;
  logic       ram_wr_en;
  logic [7:0] ram_addr;
  logic [7:0] ram_wdata;
  logic [7:0] ram_rdata;
  logic       busy;
  logic       done;
  logic       err;

  int errors;
  int checks;
  int cycles;

  // bench-side RAM and host write port
  logic [7:0] mem [0:255];
  logic [7:0] shadow [0:255];
  logic       hw_en;
  logic [7:0] hw_addr;
  logic [7:0] hw_data;
  logic       cnt_clr;
  int         rd_cnt;
  int         wr_cnt;
  int         done_cnt;
  logic [7:0] first_rd;
  logic [7:0] last_rd;
  logic       ord_bad;

  cfg_sum_guard dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .verify_req (verify_req),
    .update_req (update_req),
    .ram_rd_en  (ram_rd_en),
    .ram_wr_en  (ram_wr_en),
    .ram_addr   (ram_addr),
    .ram_wdata  (ram_wdata),
    .ram_rdata  (ram_rdata),
    .busy       (busy),
    .done       (done),
    .err        (err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (hw_en) mem[hw_addr] <= hw_data;
    if (ram_wr_en) mem[ram_addr] <= ram_wdata;
    if (ram_rd_en) ram_rdata <= mem[ram_addr];
    if (cnt_clr) begin
      rd_cnt <= 0; wr_cnt <= 0; done_cnt <= 0; ord_bad <= 1'b0;
    end else begin
      if (ram_wr_en) wr_cnt <= wr_cnt + 1;
      if (done) done_cnt <= done_cnt + 1;
      if (ram_rd_en) begin
        rd_cnt  <= rd_cnt + 1;
        last_rd <= ram_addr;
        if (rd_cnt == 0) first_rd <= ram_addr;
        else if (ram_addr != last_rd + 8'd1) ord_bad <= 1'b1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] dflt(input logic [7:0] a);
    return {a[3:0], a[7:4]} ^ 8'h5A;
  endfunction

  function automatic logic [15:0] win_sum();
    logic [15:0] s = '0;
    for (int a = 'h10; a <= 'h2D; a++) s += {8'h00, mem[a]};
    return s;
  endfunction

  function automatic logic [15:0] dflt_sum();
    logic [15:0] s = '0;
    for (int a = 'h10; a <= 'h2D; a++) s += {8'h00, dflt(8'(a))};
    return s;
  endfunction

  task automatic host_wr(input int a, input logic [7:0] d);
    hw_en = 1'b1; hw_addr = 8'(a); hw_data = d;
    @(negedge clk);
    hw_en = 1'b0;
  endtask

  task automatic fill_random();
    for (int a = 0; a < 256; a++) host_wr(a, 8'($urandom));
  endtask

  task automatic fix_csum();
    logic [15:0] s = win_sum();
    host_wr('h2E, s[7:0]);
    host_wr('h2F, s[15:8]);
  endtask

  task automatic snap();
    for (int a = 0; a < 256; a++) shadow[a] = mem[a];
  endtask

  task automatic clr_counts();
    cnt_clr = 1'b1;
    @(negedge clk);
    cnt_clr = 1'b0;
  endtask

  // Issue a request, wait for done, check the handshake; leaves one cycle after done.
  task automatic run_op(input bit v, input bit u, input string tag);
    int wait_n = 0;
    clr_counts();
    verify_req = v; update_req = u;
    @(negedge clk);
    verify_req = 1'b0; update_req = 1'b0;
    chk(busy == 1'b1, {tag, " R6 busy after request"}, busy, 1);
    while (!done && wait_n < 400) begin
      @(negedge clk);
      wait_n++;
    end
    chk(wait_n < 400, {tag, " R6 done reached"}, wait_n, 0);
    chk(busy == 1'b0, {tag, " R6 busy low with done"}, busy, 0);
    @(negedge clk);
    chk(done == 1'b0, {tag, " R6 done one cycle"}, done, 0);
  endtask

  task automatic check_outside(input string tag);
    int bad = 0;
    for (int a = 0; a < 256; a++)
      if ((a < 'h10 || a > 'h2F) && mem[a] != shadow[a]) bad++;
    chk(bad == 0, {tag, " R10 bytes outside window untouched"}, bad, 0);
  endtask

  task automatic check_restored(input string tag);
    int bad = 0;
    logic [15:0] s = dflt_sum();
    for (int a = 'h10; a <= 'h2D; a++) if (mem[a] != dflt(8'(a))) bad++;
    chk(bad == 0, {tag, " R4 defaults written"}, bad, 0);
    chk({mem['h2F], mem['h2E]} == s, {tag, " R4 checksum of defaults"},
        {mem['h2F], mem['h2E]}, s);
  endtask

  // Verify a prepared image, with the expected outcome computed here.
  task automatic verify_case(input string tag);
    bit exp_bad = ({mem['h2F], mem['h2E]} != win_sum());
    snap();
    run_op(1'b1, 1'b0, tag);
    chk(err == exp_bad, {tag, " R3 err vs computed sum"}, err, exp_bad);
    chk(rd_cnt == 32 && first_rd == 8'h10 && last_rd == 8'h2F && !ord_bad,
        {tag, " R2 read walk"}, rd_cnt, 32);
    if (exp_bad) begin
      check_restored(tag);
      chk(wr_cnt == 32, {tag, " R4 write count"}, wr_cnt, 32);
    end else begin
      chk(wr_cnt == 0, {tag, " R3 no writes on pass"}, wr_cnt, 0);
    end
    check_outside(tag);
  endtask

  // Watchdog
  initial begin
    wait (cycles > 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    errors = 0; checks = 0; cycles = 0;
    rst_n = 1'b0; verify_req = 1'b0; update_req = 1'b0;
    hw_en = 1'b0; hw_addr = '0; hw_data = '0; cnt_clr = 1'b0;
    ram_rdata = '0;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!busy && !done && !err, "R1 outputs low in reset", {busy, done, err}, 0);
    chk(!ram_rd_en && !ram_wr_en, "R1 no RAM access in reset", {ram_rd_en, ram_wr_en}, 0);
    rst_n = 1'b1;
    fill_random();
    clr_counts();
    repeat (4) @(negedge clk);
    chk(!busy && !done && !err, "R1 outputs low after reset", {busy, done, err}, 0);
    chk(rd_cnt == 0 && wr_cnt == 0, "R1 idle RAM after reset", rd_cnt + wr_cnt, 0);

    // Directed: correct checksum on random data
    fix_csum();
    verify_case("pass_random");

    // Random pass / fail mix, each fail followed by a repeat verify
    for (int t = 0; t < 8; t++) begin
      fill_random();
      fix_csum();
      if ($urandom % 2) host_wr('h10 + ($urandom % 32), 8'($urandom));
      verify_case("rand");
      if (err) begin
        verify_case("rand_repeat");
        chk(err == 1'b0, "R4 repeat verify passes", err, 0);
      end
    end

    // Corner: all FFh, total 1DE2h
    for (int a = 'h10; a <= 'h2D; a++) host_wr(a, 8'hFF);
    host_wr('h2E, 8'hE2); host_wr('h2F, 8'h1D);
    verify_case("all_ff");
    chk(err == 1'b0, "R3 all FFh passes with 1DE2h", err, 0);

    // Corner: all zero
    for (int a = 'h10; a <= 'h2F; a++) host_wr(a, 8'h00);
    verify_case("all_zero");
    chk(err == 1'b0, "R3 all zero passes", err, 0);

    // Corner: upper checksum byte wrong only
    fill_random();
    fix_csum();
    host_wr('h2F, mem['h2F] ^ 8'h01);
    verify_case("hi_only");
    chk(err == 1'b1, "R3 upper byte mismatch detected", err, 1);

    // Update while err set: err holds, checksum rewritten (R5, R8)
    for (int a = 'h10; a <= 'h2D; a++) host_wr(a, 8'($urandom));
    snap();
    run_op(1'b0, 1'b1, "update");
    chk(err == 1'b1, "R8 err held through update", err, 1);
    chk({mem['h2F], mem['h2E]} == win_sum(), "R5 checksum stored",
        {mem['h2F], mem['h2E]}, win_sum());
    chk(rd_cnt == 30 && first_rd == 8'h10 && last_rd == 8'h2D && !ord_bad,
        "R5 update read walk", rd_cnt, 30);
    chk(wr_cnt == 2, "R5 two writes", wr_cnt, 2);
    check_outside("update");
    verify_case("after_update");
    chk(err == 1'b0, "R8 err cleared by verify", err, 0);

    // Verify request during a running update is ignored (R7)
    fill_random();
    fix_csum();
    host_wr('h20, mem['h20] + 8'd3);
    snap();
    clr_counts();
    update_req = 1'b1;
    @(negedge clk);
    update_req = 1'b0;
    repeat (3) @(negedge clk);
    verify_req = 1'b1;
    @(negedge clk);
    verify_req = 1'b0;
    repeat (80) @(negedge clk);
    chk(done_cnt == 1, "R7 single done for update", done_cnt, 1);
    chk(!busy && err == 1'b0, "R7 no verify started", {busy, err}, 0);
    chk({mem['h2F], mem['h2E]} == win_sum() && mem['h20] == shadow['h20],
        "R7 update result intact", {mem['h2F], mem['h2E]}, win_sum());

    // Update request during a failing verify is ignored (R7)
    host_wr('h2E, mem['h2E] ^ 8'h40);
    snap();
    clr_counts();
    verify_req = 1'b1;
    @(negedge clk);
    verify_req = 1'b0;
    repeat (5) @(negedge clk);
    update_req = 1'b1;
    @(negedge clk);
    update_req = 1'b0;
    repeat (120) @(negedge clk);
    chk(done_cnt == 1, "R7 single done for verify", done_cnt, 1);
    chk(err == 1'b1, "R7 verify outcome kept", err, 1);
    check_restored("collide");

    // Both requests at once: verify wins (R9)
    fill_random();
    fix_csum();
    host_wr('h2D, mem['h2D] ^ 8'h80);
    snap();
    run_op(1'b1, 1'b1, "both");
    chk(err == 1'b1, "R9 verify chosen", err, 1);
    chk(rd_cnt == 32, "R9 verify-length read walk", rd_cnt, 32);
    check_restored("both");
    check_outside("both");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule